// File: doc/BRIEF.md
# Pipelined Register-Array Memory with Parameterized Latency

This block is a small register-array memory with three access points: a read-only port, a write-only port and a shared port that can either read or write in a given cycle. All ports share one clock. The storage itself answers reads at once and commits writes on the clock edge. Read and write latency are set by parameters, and all of it comes from delay registers placed in front of that storage.

The shared port is built from one internal read path and one internal write path. Both are fed from the same address input, and the write-mode input chooses between them. Reads of addresses beyond the last word return zero, so a depth that is not a power of two behaves the same in every simulator and in hardware. The stored words have no reset. Only the enable stages of the delay pipes are cleared, so nothing issued before or during reset can reach the storage.

Top module: `latmem`

## Requirements
- R1: On the read-only port, `rd_en` is delayed by READ_LATENCY-1 clearable stages to form a capture strobe. A chain of READ_LATENCY address stages, where stage 0 takes `rd_addr` and stage k takes stage k-1, advances on every edge where that strobe is 1. `rd_data` is always the word at the final stage's address.
- R2: On the write-only port, `wr_en`, `wr_mask`, `wr_addr` and `wr_data` are each delayed by WRITE_LATENCY-1 stages. On the following edge the word is stored only if both the delayed enable and the delayed mask are 1. With mask 0, the word keeps its old value.
- R3: On edges where the capture strobe is 0, the read address stages keep their value. `rd_data` then changes only when the addressed word is written.
- R4: The read side of the shared port follows the rules of R1, using `rw_en & ~rw_wmode` as its enable and `rw_addr` as its address. Its data appears on `rw_rdata`.
- R5: The write side of the shared port follows the rules of R2, using `rw_en & rw_wmode` as enable and `rw_wmask`, `rw_addr` and `rw_wdata` as mask, address and data.
- R6: Suppose a write reaches the storage in the same cycle that a read path points at the same word. The read data shows the old word in that cycle and the new word from the next cycle on.
- R7: If both write paths store to the same word on the same edge, the write-only port's data is kept.
- R8: A read at an address of DEPTH or more returns all zeros. A write at such an address changes no stored word.
- R9: While `rst` is 1, all enable stages are cleared and enables presented at the ports are discarded. A write or read capture issued during reset never takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every port |
| rst | input | 1 | Synchronous active-high reset of the enable stages |
| rd_en | input | 1 | Read-only port enable |
| rd_addr | input | ADDR_W | Read-only port address |
| rd_data | output | DATA_W | Read-only port data |
| wr_en | input | 1 | Write-only port enable |
| wr_mask | input | 1 | Write-only port one-bit mask |
| wr_addr | input | ADDR_W | Write-only port address |
| wr_data | input | DATA_W | Write-only port data |
| rw_en | input | 1 | Shared port enable |
| rw_wmode | input | 1 | Shared port direction, 1 = write, 0 = read |
| rw_addr | input | ADDR_W | Shared port address for both directions |
| rw_wdata | input | DATA_W | Shared port write data |
| rw_wmask | input | 1 | Shared port one-bit write mask |
| rw_rdata | output | DATA_W | Shared port read data |

## Verification
The bench builds the block with DATA_W=16, DEPTH=12, READ_LATENCY=2 and WRITE_LATENCY=3. A depth of twelve behind a four-bit address makes the zero-returning out-of-range reads and the discarded out-of-range writes reachable. A read latency of two puts a real register between the read enable and the capture strobe, so the one-cycle skew between enable and captured address is exercised. A write latency of three lets writes sit in flight while reads already point at the same word, which brings the old-then-new ordering and the two-writer priority within reach of random traffic.

// File: rtl/latmem_pkg.sv
package latmem_pkg;

    // Address width for a given word count; never narrower than one bit.
    function automatic int unsigned addr_width(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    // Which access point a core write came from; the write-only port outranks the shared one.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_DED  = 2'd1,
        SRC_RW   = 2'd2
    } wr_src_e;

endpackage

// File: rtl/latmem_shift.sv
// Plain delay line; STAGES = 0 is a wire. CLR selects whether reset clears it.
module latmem_shift #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 1,
    parameter bit          CLR    = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (STAGES == 0) begin : g_wire
            assign q = d;
        end else begin : g_regs
            logic [W-1:0] st [STAGES];
            always_ff @(posedge clk) begin
                if (CLR && rst) begin
                    for (int k = 0; k < int'(STAGES); k++) st[k] <= '0;
                end else begin
                    st[0] <= d;
                    for (int k = 1; k < int'(STAGES); k++) st[k] <= st[k-1];
                end
            end
            assign q = st[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/latmem_gated_pipe.sv
// Delay line whose every stage advances only when ld is high.
module latmem_gated_pipe #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 1
) (
    input  logic         clk,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (ld) begin
            st[0] <= d;
            for (int k = 1; k < int'(STAGES); k++) st[k] <= st[k-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/latmem_rd_path.sv
// One read path: enable delayed LAT-1 stages becomes the capture strobe,
// address delayed LAT gated stages feeds the combinational core read.
module latmem_rd_path #(
    parameter int unsigned AW  = 4,
    parameter int unsigned LAT = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] core_addr,
    output logic          cap
);
    generate
        if (LAT == 0) begin : g_direct
            assign core_addr = addr;
            assign cap       = 1'b1;
        end else begin : g_piped
            latmem_shift #(.W(1), .STAGES(LAT-1), .CLR(1'b1)) u_en_dly (
                .clk (clk),
                .rst (rst),
                .d   (en),
                .q   (cap)
            );
            latmem_gated_pipe #(.W(AW), .STAGES(LAT)) u_addr_dly (
                .clk (clk),
                .ld  (cap),
                .d   (addr),
                .q   (core_addr)
            );
        end
    endgenerate
endmodule

// File: rtl/latmem_wr_path.sv
// One write path: enable (clearable) and the mask/address/data beat are
// each delayed LAT-1 stages; the core commits on the following edge.
module latmem_wr_path #(
    parameter int unsigned AW  = 4,
    parameter int unsigned DW  = 8,
    parameter int unsigned LAT = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          mask,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [DW-1:0] wdata
);
    typedef struct packed {
        logic          mask;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } wr_beat_t;

    localparam int unsigned BEAT_W = $bits(wr_beat_t);

    wr_beat_t beat_in;
    wr_beat_t beat_out;
    logic     en_q;

    assign beat_in = '{mask: mask, addr: addr, data: data};

    latmem_shift #(.W(1), .STAGES(LAT-1), .CLR(1'b1)) u_en_dly (
        .clk (clk),
        .rst (rst),
        .d   (en),
        .q   (en_q)
    );

    latmem_shift #(.W(BEAT_W), .STAGES(LAT-1), .CLR(1'b0)) u_beat_dly (
        .clk (clk),
        .rst (rst),
        .d   (beat_in),
        .q   (beat_out)
    );

    assign we    = en_q & beat_out.mask;
    assign waddr = beat_out.addr;
    assign wdata = beat_out.data;
endmodule

// File: rtl/latmem_core.sv
// Zero-latency read, one-edge write storage with two read and two write ports.
module latmem_core #(
    parameter int unsigned DW    = 8,
    parameter int unsigned DEPTH = 12,
    parameter int unsigned AW    = 4
) (
    input  logic          clk,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_a,
    output logic [DW-1:0] rdata_b,
    input  logic          we_a,
    input  logic [AW-1:0] waddr_a,
    input  logic [DW-1:0] wdata_a,
    input  logic          we_b,
    input  logic [AW-1:0] waddr_b,
    input  logic [DW-1:0] wdata_b
);
    import latmem_pkg::*;

    logic [DW-1:0] mem [DEPTH];

    logic    hit_ra, hit_rb, hit_wa, hit_wb;
    wr_src_e src_sel;

    assign hit_ra = 32'(raddr_a) < DEPTH;
    assign hit_rb = 32'(raddr_b) < DEPTH;
    assign hit_wa = 32'(waddr_a) < DEPTH;
    assign hit_wb = 32'(waddr_b) < DEPTH;

    // Who owns a word when both write paths aim at it on one edge.
    always_comb begin
        if (we_a && hit_wa)      src_sel = SRC_DED;
        else if (we_b && hit_wb) src_sel = SRC_RW;
        else                     src_sel = SRC_NONE;
    end

    always_ff @(posedge clk) begin
        if (we_b && hit_wb && !(src_sel == SRC_DED && waddr_a == waddr_b))
            mem[waddr_b] <= wdata_b;
        if (src_sel == SRC_DED)
            mem[waddr_a] <= wdata_a;
    end

    assign rdata_a = hit_ra ? mem[raddr_a] : '0;
    assign rdata_b = hit_rb ? mem[raddr_b] : '0;
endmodule

// File: rtl/latmem.sv
module latmem #(
    parameter int unsigned DATA_W        = 16,
    parameter int unsigned DEPTH         = 12,
    parameter int unsigned READ_LATENCY  = 2,
    parameter int unsigned WRITE_LATENCY = 3,
    localparam int unsigned ADDR_W       = latmem_pkg::addr_width(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic              wr_mask,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rw_en,
    input  logic              rw_wmode,
    input  logic [ADDR_W-1:0] rw_addr,
    input  logic [DATA_W-1:0] rw_wdata,
    input  logic              rw_wmask,
    output logic [DATA_W-1:0] rw_rdata
);
    // Enables never enter the pipes while reset is high.
    logic rd_go, rwr_go, wr_go, rww_go;
    assign rd_go  = rd_en & ~rst;
    assign rwr_go = rw_en & ~rw_wmode & ~rst;
    assign wr_go  = wr_en & ~rst;
    assign rww_go = rw_en &  rw_wmode & ~rst;

    logic              rd_cap_a, rd_cap_b;
    logic [ADDR_W-1:0] core_raddr_a, core_raddr_b;
    logic              core_we_a, core_we_b;
    logic [ADDR_W-1:0] core_waddr_a, core_waddr_b;
    logic [DATA_W-1:0] core_wdata_a, core_wdata_b;

    latmem_rd_path #(.AW(ADDR_W), .LAT(READ_LATENCY)) u_rd_ded (
        .clk       (clk),
        .rst       (rst),
        .en        (rd_go),
        .addr      (rd_addr),
        .core_addr (core_raddr_a),
        .cap       (rd_cap_a)
    );

    latmem_rd_path #(.AW(ADDR_W), .LAT(READ_LATENCY)) u_rd_shared (
        .clk       (clk),
        .rst       (rst),
        .en        (rwr_go),
        .addr      (rw_addr),
        .core_addr (core_raddr_b),
        .cap       (rd_cap_b)
    );

    latmem_wr_path #(.AW(ADDR_W), .DW(DATA_W), .LAT(WRITE_LATENCY)) u_wr_ded (
        .clk   (clk),
        .rst   (rst),
        .en    (wr_go),
        .mask  (wr_mask),
        .addr  (wr_addr),
        .data  (wr_data),
        .we    (core_we_a),
        .waddr (core_waddr_a),
        .wdata (core_wdata_a)
    );

    latmem_wr_path #(.AW(ADDR_W), .DW(DATA_W), .LAT(WRITE_LATENCY)) u_wr_shared (
        .clk   (clk),
        .rst   (rst),
        .en    (rww_go),
        .mask  (rw_wmask),
        .addr  (rw_addr),
        .data  (rw_wdata),
        .we    (core_we_b),
        .waddr (core_waddr_b),
        .wdata (core_wdata_b)
    );

    latmem_core #(.DW(DATA_W), .DEPTH(DEPTH), .AW(ADDR_W)) u_core (
        .clk     (clk),
        .raddr_a (core_raddr_a),
        .raddr_b (core_raddr_b),
        .rdata_a (rd_data),
        .rdata_b (rw_rdata),
        .we_a    (core_we_a),
        .waddr_a (core_waddr_a),
        .wdata_a (core_wdata_a),
        .we_b    (core_we_b),
        .waddr_b (core_waddr_b),
        .wdata_b (core_wdata_b)
    );
endmodule

// File: rtl/latmem_chk.sv
module latmem_chk #(
    parameter int unsigned DATA_W       = 16,
    parameter int unsigned DEPTH        = 12,
    parameter int unsigned ADDR_W       = 4,
    parameter int unsigned READ_LATENCY = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] rd_data,
    input logic [DATA_W-1:0] rw_rdata,
    input logic              rd_cap_a,
    input logic              rd_cap_b,
    input logic [ADDR_W-1:0] core_raddr_a,
    input logic [ADDR_W-1:0] core_raddr_b,
    input logic              core_we_a,
    input logic [ADDR_W-1:0] core_waddr_a,
    input logic [DATA_W-1:0] core_wdata_a
);
    localparam bit PIPED = READ_LATENCY > 0;

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (PIPED && !rd_cap_a) |=> $stable(core_raddr_a));

    p_shared_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (PIPED && !rd_cap_b) |=> $stable(core_raddr_b));

    p_oor_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (32'(core_raddr_a) >= DEPTH) |-> (rd_data == '0));

    p_shared_oor_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (32'(core_raddr_b) >= DEPTH) |-> (rw_rdata == '0));

    // R2 and R7: a committed write-only store is what the parked read path sees next.
    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        (PIPED && core_we_a && !rd_cap_a && core_waddr_a == core_raddr_a &&
         32'(core_waddr_a) < DEPTH) |=> (rd_data == $past(core_wdata_a)));
endmodule

bind latmem latmem_chk #(
    .DATA_W       (DATA_W),
    .DEPTH        (DEPTH),
    .ADDR_W       (ADDR_W),
    .READ_LATENCY (READ_LATENCY)
) u_latmem_chk (
    .clk          (clk),
    .rst          (rst),
    .rd_data      (rd_data),
    .rw_rdata     (rw_rdata),
    .rd_cap_a     (rd_cap_a),
    .rd_cap_b     (rd_cap_b),
    .core_raddr_a (core_raddr_a),
    .core_raddr_b (core_raddr_b),
    .core_we_a    (core_we_a),
    .core_waddr_a (core_waddr_a),
    .core_wdata_a (core_wdata_a)
);

// File: tb/latmem_bench.sv
`timescale 1ns/1ps
module latmem_bench;
    localparam int RL    = 2;
    localparam int WL    = 3;
    localparam int DEPTH = 12;
    localparam int DW    = 16;
    localparam int AW    = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          rd_en, wr_en, wr_mask, rw_en, rw_wmode, rw_wmask;
    logic [AW-1:0] rd_addr, wr_addr, rw_addr;
    logic [DW-1:0] wr_data, rw_wdata;
    logic [DW-1:0] rd_data, rw_rdata;

    always #2.5 clk = ~clk;

    latmem #(.DATA_W(DW), .DEPTH(DEPTH), .READ_LATENCY(RL), .WRITE_LATENCY(WL)) u_latmem (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_mask  (wr_mask),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rw_en    (rw_en),
        .rw_wmode (rw_wmode),
        .rw_addr  (rw_addr),
        .rw_wdata (rw_wdata),
        .rw_wmask (rw_wmask),
        .rw_rdata (rw_rdata)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    string tag    = "R9";

    // Reference model state, built from the requirements.
    logic          m_ren_a [RL-1];
    logic          m_ren_b [RL-1];
    logic [AW-1:0] m_ra_a  [RL];
    logic [AW-1:0] m_ra_b  [RL];
    bit            m_rk_a  [RL];
    bit            m_rk_b  [RL];
    logic          m_we_a [WL-1], m_wm_a [WL-1], m_we_b [WL-1], m_wm_b [WL-1];
    logic [AW-1:0] m_wa_a [WL-1], m_wa_b [WL-1];
    logic [DW-1:0] m_wd_a [WL-1], m_wd_b [WL-1];
    logic [DW-1:0] m_mem [DEPTH];
    bit            m_mk  [DEPTH];

    task automatic chk(input string t, input string what, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h at %0t", t, what, got, exp, $time);
        end
    endtask

    task automatic model_step();
        logic ea, eb, wa_in, wb_in;
        ea    = rd_en & ~rst;
        eb    = rw_en & ~rw_wmode & ~rst;
        wa_in = wr_en & ~rst;
        wb_in = rw_en & rw_wmode & ~rst;
        // core commits from the last write stages; write-only port last so it wins
        if (m_we_b[WL-2] && m_wm_b[WL-2] && int'(m_wa_b[WL-2]) < DEPTH) begin
            m_mem[m_wa_b[WL-2]] = m_wd_b[WL-2];
            m_mk[m_wa_b[WL-2]]  = 1'b1;
        end
        if (m_we_a[WL-2] && m_wm_a[WL-2] && int'(m_wa_a[WL-2]) < DEPTH) begin
            m_mem[m_wa_a[WL-2]] = m_wd_a[WL-2];
            m_mk[m_wa_a[WL-2]]  = 1'b1;
        end
        if (m_ren_a[RL-2]) begin
            for (int k = RL-1; k > 0; k--) begin m_ra_a[k] = m_ra_a[k-1]; m_rk_a[k] = m_rk_a[k-1]; end
            m_ra_a[0] = rd_addr; m_rk_a[0] = 1'b1;
        end
        if (m_ren_b[RL-2]) begin
            for (int k = RL-1; k > 0; k--) begin m_ra_b[k] = m_ra_b[k-1]; m_rk_b[k] = m_rk_b[k-1]; end
            m_ra_b[0] = rw_addr; m_rk_b[0] = 1'b1;
        end
        for (int k = RL-2; k > 0; k--) begin m_ren_a[k] = m_ren_a[k-1]; m_ren_b[k] = m_ren_b[k-1]; end
        m_ren_a[0] = ea; m_ren_b[0] = eb;
        for (int k = WL-2; k > 0; k--) begin
            m_we_a[k] = m_we_a[k-1]; m_wm_a[k] = m_wm_a[k-1]; m_wa_a[k] = m_wa_a[k-1]; m_wd_a[k] = m_wd_a[k-1];
            m_we_b[k] = m_we_b[k-1]; m_wm_b[k] = m_wm_b[k-1]; m_wa_b[k] = m_wa_b[k-1]; m_wd_b[k] = m_wd_b[k-1];
        end
        m_we_a[0] = wa_in; m_wm_a[0] = wr_mask;  m_wa_a[0] = wr_addr; m_wd_a[0] = wr_data;
        m_we_b[0] = wb_in; m_wm_b[0] = rw_wmask; m_wa_b[0] = rw_addr; m_wd_b[0] = rw_wdata;
        if (rst) begin
            for (int k = 0; k < RL-1; k++) begin m_ren_a[k] = 1'b0; m_ren_b[k] = 1'b0; end
            for (int k = 0; k < WL-1; k++) begin m_we_a[k] = 1'b0; m_we_b[k] = 1'b0; end
        end
    endtask

    function automatic bit model_word(input bit known, input logic [AW-1:0] a, output logic [DW-1:0] v);
        v = '0;
        if (!known) return 1'b0;
        if (int'(a) >= DEPTH) return 1'b1;
        if (!m_mk[a]) return 1'b0;
        v = m_mem[a];
        return 1'b1;
    endfunction

    task automatic compare_outputs();
        logic [DW-1:0] v;
        if (model_word(m_rk_a[RL-1], m_ra_a[RL-1], v)) chk(tag, "rd_data", rd_data, v);
        if (model_word(m_rk_b[RL-1], m_ra_b[RL-1], v)) chk(tag, "rw_rdata", rw_rdata, v);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_outputs();
    endtask

    task automatic idle_inputs();
        rd_en = 0; wr_en = 0; rw_en = 0; rw_wmode = 0; wr_mask = 0; rw_wmask = 0;
    endtask

    task automatic write_ded(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic m);
        wr_en = 1; wr_addr = a; wr_data = d; wr_mask = m;
        tick();
        wr_en = 0;
    endtask

    task automatic read_ded(input logic [AW-1:0] a);
        rd_en = 1; rd_addr = a;
        repeat (RL + 1) tick();
        rd_en = 0;
    endtask

    initial begin
        for (int k = 0; k < RL-1; k++) begin m_ren_a[k] = 0; m_ren_b[k] = 0; end
        for (int k = 0; k < RL; k++) begin m_rk_a[k] = 0; m_rk_b[k] = 0; m_ra_a[k] = '0; m_ra_b[k] = '0; end
        for (int k = 0; k < WL-1; k++) begin
            m_we_a[k] = 0; m_we_b[k] = 0; m_wm_a[k] = 0; m_wm_b[k] = 0;
            m_wa_a[k] = '0; m_wa_b[k] = '0; m_wd_a[k] = '0; m_wd_b[k] = '0;
        end
        for (int k = 0; k < DEPTH; k++) begin m_mk[k] = 0; m_mem[k] = '0; end
        rst = 1; idle_inputs();
        rd_addr = '0; wr_addr = '0; rw_addr = '0; wr_data = '0; rw_wdata = '0;
        @(negedge clk);
        repeat (3) tick();
        rst = 0;

        // R2: fill every word through the write-only port
        tag = "R2";
        for (int a = 0; a < DEPTH; a++) write_ded(AW'(a), DW'(16'h1000 + a * 17), 1'b1);
        repeat (WL) tick();

        // R1: stream reads with the enable held high
        tag = "R1";
        rd_en = 1;
        for (int a = 0; a < DEPTH; a++) begin rd_addr = AW'(a); tick(); end
        rd_en = 0;
        repeat (RL + 1) tick();

        // R2: masked-off write leaves the word alone
        tag = "R2";
        write_ded(4'd4, 16'hFFFF, 1'b0);
        repeat (WL) tick();
        read_ded(4'd4);
        chk("R2", "masked word", rd_data, DW'(16'h1000 + 4 * 17));

        // R3: address moves while enable is low; output stays
        tag = "R3";
        rd_addr = 4'd7;
        repeat (4) tick();
        chk("R3", "held read", rd_data, DW'(16'h1000 + 4 * 17));

        // R5: shared port write, then masked-off write
        tag = "R5";
        rw_en = 1; rw_wmode = 1; rw_addr = 4'd9; rw_wdata = 16'hBEEF; rw_wmask = 1; tick();
        rw_addr = 4'd10; rw_wdata = 16'h0BAD; rw_wmask = 0; tick();
        rw_en = 0; rw_wmode = 0;
        repeat (WL) tick();

        // R4: shared port read
        tag = "R4";
        rw_en = 1; rw_wmode = 0; rw_addr = 4'd9;
        repeat (RL + 1) tick();
        chk("R4", "shared read", rw_rdata, 16'hBEEF);
        rw_addr = 4'd10;
        repeat (RL + 1) tick();
        rw_en = 0;
        chk("R5", "shared masked", rw_rdata, DW'(16'h1000 + 10 * 17));

        // R6: read parked on word 2 while a write to it lands
        tag = "R6";
        read_ded(4'd2);
        wr_en = 1; wr_addr = 4'd2; wr_data = 16'h2222; wr_mask = 1;
        tick(); wr_en = 0;
        tick();
        chk("R6", "old word before commit", rd_data, DW'(16'h1000 + 2 * 17));
        tick();
        chk("R6", "new word after commit", rd_data, 16'h2222);

        // R7: both writers hit word 6 together
        tag = "R7";
        wr_en = 1; wr_addr = 4'd6; wr_data = 16'h6A6A; wr_mask = 1;
        rw_en = 1; rw_wmode = 1; rw_addr = 4'd6; rw_wdata = 16'h6B6B; rw_wmask = 1;
        tick(); idle_inputs();
        repeat (WL) tick();
        read_ded(4'd6);
        chk("R7", "priority", rd_data, 16'h6A6A);

        // R8: reads and writes past the last word
        tag = "R8";
        read_ded(4'd13);
        chk("R8", "out of range read", rd_data, 16'h0000);
        write_ded(4'd14, 16'h1414, 1'b1);
        repeat (WL) tick();
        rw_en = 1; rw_wmode = 0; rw_addr = 4'd15;
        repeat (RL + 1) tick();
        rw_en = 0;
        chk("R8", "shared out of range", rw_rdata, 16'h0000);

        // R9: traffic during reset is dropped
        tag = "R9";
        read_ded(4'd1);
        rst = 1;
        wr_en = 1; wr_addr = 4'd1; wr_data = 16'hDEAD; wr_mask = 1;
        rw_en = 1; rw_wmode = 1; rw_addr = 4'd0; rw_wdata = 16'hCAFE; rw_wmask = 1;
        rd_en = 1; rd_addr = 4'd3;
        repeat (3) tick();
        idle_inputs(); rst = 0;
        repeat (WL + 2) tick();
        chk("R9", "no write or capture in reset", rd_data, DW'(16'h1000 + 1 * 17));
        rw_en = 1; rw_wmode = 0; rw_addr = 4'd0;
        repeat (RL + 1) tick();
        rw_en = 0;
        chk("R9", "shared word untouched", rw_rdata, DW'(16'h1000));

        // R6 and the rest: seeded random traffic against the model
        tag = "R6";
        void'($urandom(32'd20240607));
        for (int n = 0; n < 3000; n++) begin
            rd_en    = ($urandom % 2) == 0;
            rd_addr  = AW'($urandom % 16);
            wr_en    = ($urandom % 3) == 0;
            wr_mask  = ($urandom % 4) != 0;
            wr_addr  = AW'($urandom % 16);
            wr_data  = DW'($urandom);
            rw_en    = ($urandom % 2) == 0;
            rw_wmode = ($urandom % 2) == 0;
            rw_wmask = ($urandom % 4) != 0;
            rw_addr  = AW'($urandom % 16);
            rw_wdata = DW'($urandom);
            tick();
        end
        idle_inputs();
        repeat (WL + 1) tick();

        // R1: final sweep of every word
        tag = "R1";
        rd_en = 1;
        for (int a = 0; a < 16; a++) begin rd_addr = AW'(a); tick(); end
        rd_en = 0;
        repeat (RL + 1) tick();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog %s: got hung expected finished", tag);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule